// File: doc/BRIEF.md
# Element-Width Packed Vector Register File

This block holds 128 general registers of 64 bits each. On top of them sits a sequential engine that runs a vector add. Elements of 8, 16, 32 or 64 bits are packed end to end, starting in the lowest bits of a base register and continuing into the registers above it. An operation names a destination base, two source bases, a vector length and a 2-bit width code. The engine then handles one element per clock.

Each result is cut to the element width and written back through byte-lane enables. A narrow update therefore touches only its own bytes and never rewrites the whole register. The order of bytes inside a register is fixed: element k of width w always begins at packed bit k*w, and no endianness setting exists that could change this.

A whole-word debug port lets the environment load and inspect registers. Its writes take effect only while the engine is idle. A `start` strobe launches an operation, and a one-cycle `done` pulse ends it.

Top module: `evrf_top`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and every register reads as zero through the debug port.
- R2: While the engine is idle, a debug write (`dbg_we`=1) stores the full 64-bit `dbg_wdata` at `dbg_addr`. `dbg_rdata` always shows the register selected by `dbg_addr`, combinationally.
- R3: Element k of an operand with base register B and element width w lives in register B + floor(k*w/64), starting at bit (k*w mod 64). The lowest bits of the base register hold element 0.
- R4: Each destination element equals the sum of the two source elements, truncated to w bits. The carry out is dropped and never reaches the next element.
- R5: An element write changes only the w/8 bytes of that element. Every other byte of the destination register keeps its old value, including bytes above the last element.
- R6: The width code selects the element width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits.
- R7: Take the edge at which `start` is accepted as edge 0. One element is written at each of edges 1 to VL, and `busy` is high in between. `done` is then high for exactly one cycle, after edge VL.
- R8: A vector length of 0 writes nothing. `done` pulses right after edge 0 and `busy` stays low.
- R9: A `start` that arrives while `busy` is high is ignored. The operation in progress finishes with its original parameters.
- R10: A debug write that arrives while `busy` is high is ignored.
- R11: Consider an element whose destination, source A or source B register index would be above 127. That element's write is suppressed, and `err` goes to 1 and stays there until the next accepted `start`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a vector add when idle |
| dst_base | input | 7 | Destination base register |
| src_a_base | input | 7 | First source base register |
| src_b_base | input | 7 | Second source base register |
| vec_len | input | 7 | Vector length, 0 to 64 (larger values act as 64) |
| ew_code | input | 2 | Element width code (see R6) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Register index overflow seen in the last operation |
| dbg_we | input | 1 | Debug whole-word write strobe |
| dbg_addr | input | 7 | Debug register index |
| dbg_wdata | input | 64 | Debug write data |
| dbg_rdata | output | 64 | Debug read data |

## Verification
The bench sweeps every width code against vector lengths of 1, 5, 17 and 64, with fresh register contents each time. After each run it compares all 128 registers with a model that treats the file as one flat bit string, so packing, spill into the following registers and untouched neighbour bytes are all checked at once. A design that got the spill arithmetic wrong would write into the wrong register. One that lacked byte enables would wipe the bytes next to an element. One that let the carry propagate would corrupt the next element, and the all-ones plus one cases show this directly.

Further tests cover operations that run past register 127 through the destination and through a source, where a design without the guard would wrap around and overwrite low registers. They also cover a zero vector length, a stray `start` and debug write in the middle of a run, and the cycle count from `start` to `done`. A design with an off-by-one in its element counter would show up in that count.

// File: rtl/evrf_pkg.sv
package evrf_pkg;

  typedef enum logic [1:0] {
    EW_8  = 2'd0,
    EW_16 = 2'd1,
    EW_32 = 2'd2,
    EW_64 = 2'd3
  } ew_t;

  // log2 of the element width in bits
  function automatic int unsigned ew_log2_bits(ew_t c);
    return 32'(c) + 32'd3;
  endfunction

  // element width in bytes
  function automatic int unsigned ew_bytes(ew_t c);
    return 32'd1 << 32'(c);
  endfunction

endpackage

// File: rtl/evrf_regfile.sv
module evrf_regfile #(
  parameter int NREGS = 128,
  parameter int XLEN  = 64,
  localparam int AW   = $clog2(NREGS),
  localparam int NB   = XLEN / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [NB-1:0]   wbe,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   ra_a,
  input  logic [AW-1:0]   ra_b,
  input  logic [AW-1:0]   ra_c,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b,
  output logic [XLEN-1:0] rd_c
);

  // one independent byte-wide array per lane: a lane is written only when
  // its enable is set, so no read-modify-write of the full word exists
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] cells [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int r = 0; r < NREGS; r++) cells[r] <= '0;
      end else if (we && wbe[g]) begin
        cells[waddr] <= wdata[g*8 +: 8];
      end
    end

    assign rd_a[g*8 +: 8] = cells[ra_a];
    assign rd_b[g*8 +: 8] = cells[ra_b];
    assign rd_c[g*8 +: 8] = cells[ra_c];
  end

endmodule

// File: rtl/evrf_addr_gen.sv
module evrf_addr_gen
  import evrf_pkg::*;
#(
  parameter int NREGS = 128,
  parameter int XLEN  = 64,
  parameter int MAXVL = 64,
  localparam int AW   = $clog2(NREGS),
  localparam int IDXW = $clog2(MAXVL),
  localparam int XL2  = $clog2(XLEN),
  localparam int BW   = XL2 - 3
) (
  input  logic [AW-1:0]   base,
  input  logic [IDXW-1:0] idx,
  input  ew_t             ew,
  output logic [AW-1:0]   reg_idx,
  output logic [BW-1:0]   byte_off,
  output logic            out_of_range
);

  localparam int PW = IDXW + XL2 + 1;
  localparam int SW = ((AW > PW) ? AW : PW) + 1;

  // packed bit position of element idx (LSB0, contiguous)
  function automatic logic [PW-1:0] bit_pos(logic [IDXW-1:0] k, ew_t c);
    return PW'(k) << ew_log2_bits(c);
  endfunction

  logic [PW-1:0] pos;
  logic [SW-1:0] full_idx;

  always_comb begin
    pos          = bit_pos(idx, ew);
    full_idx     = SW'(base) + SW'(pos >> XL2);
    reg_idx      = full_idx[AW-1:0];
    byte_off     = pos[XL2-1:3];
    out_of_range = full_idx > SW'(NREGS - 1);
  end

endmodule

// File: rtl/evrf_elem_add.sv
module evrf_elem_add
  import evrf_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int NB  = XLEN / 8,
  localparam int BW  = $clog2(NB)
) (
  input  logic [XLEN-1:0] a_word,
  input  logic [XLEN-1:0] b_word,
  input  logic [BW-1:0]   a_off,
  input  logic [BW-1:0]   b_off,
  input  logic [BW-1:0]   d_off,
  input  ew_t             ew,
  output logic [XLEN-1:0] wdata,
  output logic [NB-1:0]   wbe
);

  function automatic logic [XLEN-1:0] width_mask(ew_t c);
    logic [XLEN:0] t;
    t = ((XLEN+1)'(1) << (32'd8 << 32'(c))) - (XLEN+1)'(1);
    return t[XLEN-1:0];
  endfunction

  function automatic logic [XLEN-1:0] pick(logic [XLEN-1:0] w, logic [BW-1:0] off, ew_t c);
    return (w >> {off, 3'b000}) & width_mask(c);
  endfunction

  function automatic logic [NB-1:0] byte_lanes(logic [BW-1:0] off, ew_t c);
    logic [NB:0] t;
    t = ((NB+1)'(1) << ew_bytes(c)) - (NB+1)'(1);
    return t[NB-1:0] << off;
  endfunction

  logic [XLEN-1:0] sum_el;

  always_comb begin
    // truncation to the element width drops the carry out
    sum_el = (pick(a_word, a_off, ew) + pick(b_word, b_off, ew)) & width_mask(ew);
    wdata  = sum_el << {d_off, 3'b000};
    wbe    = byte_lanes(d_off, ew);
  end

endmodule

// File: rtl/evrf_top.sv
module evrf_top
  import evrf_pkg::*;
#(
  parameter int NREGS = 128,
  parameter int XLEN  = 64,
  parameter int MAXVL = 64,
  localparam int AW   = $clog2(NREGS),
  localparam int IDXW = $clog2(MAXVL),
  localparam int VLW  = IDXW + 1,
  localparam int NB   = XLEN / 8,
  localparam int BW   = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   dst_base,
  input  logic [AW-1:0]   src_a_base,
  input  logic [AW-1:0]   src_b_base,
  input  logic [VLW-1:0]  vec_len,
  input  logic [1:0]      ew_code,
  output logic            busy,
  output logic            done,
  output logic            err,
  input  logic            dbg_we,
  input  logic [AW-1:0]   dbg_addr,
  input  logic [XLEN-1:0] dbg_wdata,
  output logic [XLEN-1:0] dbg_rdata
);

  // captured operation
  logic            busy_q, done_q, err_q;
  logic [IDXW-1:0] idx_q;
  logic [VLW-1:0]  vl_q;
  logic [AW-1:0]   dst_q, a_q, b_q;
  ew_t             ew_q;

  // named internal events
  logic            accept, last_elem, oor_any, eng_we, dbg_take;
  logic [VLW-1:0]  vl_in;

  // address generation
  logic [AW-1:0]   d_idx, a_idx, b_idx;
  logic [BW-1:0]   d_off, a_off, b_off;
  logic            d_oor, a_oor, b_oor;

  evrf_addr_gen #(.NREGS(NREGS), .XLEN(XLEN), .MAXVL(MAXVL)) u_ag_d (
    .base(dst_q), .idx(idx_q), .ew(ew_q),
    .reg_idx(d_idx), .byte_off(d_off), .out_of_range(d_oor));
  evrf_addr_gen #(.NREGS(NREGS), .XLEN(XLEN), .MAXVL(MAXVL)) u_ag_a (
    .base(a_q), .idx(idx_q), .ew(ew_q),
    .reg_idx(a_idx), .byte_off(a_off), .out_of_range(a_oor));
  evrf_addr_gen #(.NREGS(NREGS), .XLEN(XLEN), .MAXVL(MAXVL)) u_ag_b (
    .base(b_q), .idx(idx_q), .ew(ew_q),
    .reg_idx(b_idx), .byte_off(b_off), .out_of_range(b_oor));

  // storage
  logic [XLEN-1:0] rd_a, rd_b;
  logic            rf_we;
  logic [AW-1:0]   rf_waddr;
  logic [NB-1:0]   rf_wbe, e_be;
  logic [XLEN-1:0] rf_wdata, e_wdata;

  evrf_regfile #(.NREGS(NREGS), .XLEN(XLEN)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(rf_we), .waddr(rf_waddr), .wbe(rf_wbe), .wdata(rf_wdata),
    .ra_a(a_idx), .ra_b(b_idx), .ra_c(dbg_addr),
    .rd_a(rd_a), .rd_b(rd_b), .rd_c(dbg_rdata));

  evrf_elem_add #(.XLEN(XLEN)) u_add (
    .a_word(rd_a), .b_word(rd_b),
    .a_off(a_off), .b_off(b_off), .d_off(d_off),
    .ew(ew_q), .wdata(e_wdata), .wbe(e_be));

  always_comb begin
    vl_in     = (vec_len > VLW'(MAXVL)) ? VLW'(MAXVL) : vec_len;
    accept    = start && !busy_q;
    last_elem = busy_q && (VLW'(idx_q) == vl_q - VLW'(1));
    oor_any   = busy_q && (d_oor || a_oor || b_oor);
    eng_we    = busy_q && !oor_any;
    dbg_take  = dbg_we && !busy_q;
    rf_we     = eng_we || dbg_take;
    rf_waddr  = busy_q ? d_idx   : dbg_addr;
    rf_wbe    = busy_q ? e_be    : '1;
    rf_wdata  = busy_q ? e_wdata : dbg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      idx_q  <= '0;
      vl_q   <= '0;
      dst_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      ew_q   <= EW_8;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        dst_q <= dst_base;
        a_q   <= src_a_base;
        b_q   <= src_b_base;
        ew_q  <= ew_t'(ew_code);
        vl_q  <= vl_in;
        idx_q <= '0;
        err_q <= 1'b0;
        if (vl_in == '0) done_q <= 1'b1;
        else             busy_q <= 1'b1;
      end else if (busy_q) begin
        if (oor_any) err_q <= 1'b1;
        if (last_elem) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + IDXW'(1);
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign err  = err_q;

  // assertions
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q); // R7
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    last_elem |=> (done_q && !busy_q)); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> ($stable(dst_q) && $stable(a_q) && $stable(b_q) && $stable(ew_q) && $stable(vl_q))); // R9
  AST_DBG_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && dbg_we) |-> (rf_wbe == e_be && rf_waddr == d_idx)); // R10
  AST_NO_WRITE_OOR: assert property (@(posedge clk) disable iff (!rst_n)
    oor_any |-> !rf_we); // R11
  AST_ERR_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    oor_any |=> err_q); // R11
  AST_LANES_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> ($countones(rf_wbe) == ew_bytes(ew_q))); // R5
  AST_ZERO_VL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && vl_in == '0) |=> (done_q && !busy_q)); // R8

endmodule

// File: tb/evrf_top_tb.sv
module evrf_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  dst_base = '0, src_a_base = '0, src_b_base = '0;
  logic [6:0]  vec_len = '0;
  logic [1:0]  ew_code = '0;
  logic        busy, done, err;
  logic        dbg_we = 1'b0;
  logic [6:0]  dbg_addr = '0;
  logic [63:0] dbg_wdata = '0;
  logic [63:0] dbg_rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  bit [128*64-1:0] mdl = '0;   // flat packed model of the whole file

  evrf_top u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dst_base(dst_base), .src_a_base(src_a_base), .src_b_base(src_b_base),
    .vec_len(vec_len), .ew_code(ew_code),
    .busy(busy), .done(done), .err(err),
    .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
    .dbg_rdata(dbg_rdata));

  always #4 clk = ~clk;   // 125 MHz

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(int r, int seed);
    return (64'(r) * 64'd2654435761 + 64'(seed) * 64'd40503 + 64'd1) * 64'h9E3779B97F4A7C15;
  endfunction

  task automatic dbg_write(int r, logic [63:0] v);
    @(negedge clk);
    dbg_we = 1'b1; dbg_addr = 7'(r); dbg_wdata = v;
    @(negedge clk);
    dbg_we = 1'b0;
    mdl[r*64 +: 64] = v;
  endtask

  task automatic fill(int seed);
    for (int r = 0; r < 128; r++) begin
      @(negedge clk);
      dbg_we = 1'b1; dbg_addr = 7'(r); dbg_wdata = pat(r, seed);
      mdl[r*64 +: 64] = pat(r, seed);
    end
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic verify_all(string req);
    @(negedge clk);
    for (int r = 0; r < 128; r++) begin
      dbg_addr = 7'(r);
      #1;
      check(dbg_rdata === mdl[r*64 +: 64], req, $sformatf("reg %0d", r), dbg_rdata, mdl[r*64 +: 64]);
    end
  endtask

  // element k of width bits lives at flat bit base*64 + k*bits (R3, R6)
  task automatic model_op(int d, int a, int b, int vl, int w, output bit exp_err);
    int bits;
    bits = 8 << w;
    exp_err = 1'b0;
    for (int k = 0; k < vl; k++) begin
      int dp, ap, bp;
      bit [63:0] va, vb, s;
      dp = d*64 + k*bits; ap = a*64 + k*bits; bp = b*64 + k*bits;
      if (dp + bits > 8192 || ap + bits > 8192 || bp + bits > 8192) begin
        exp_err = 1'b1;        // R11: element dropped
      end else begin
        va = '0; vb = '0;
        for (int t = 0; t < bits; t++) begin
          va[t] = mdl[ap + t];
          vb[t] = mdl[bp + t];
        end
        s = va + vb;            // R4: only the low bits are kept below
        for (int t = 0; t < bits; t++) mdl[dp + t] = s[t];
      end
    end
  endtask

  task automatic run_op(int d, int a, int b, int vl, int w, bit disturb);
    int n;
    bit exp_err;
    @(negedge clk);
    start = 1'b1; dst_base = 7'(d); src_a_base = 7'(a); src_b_base = 7'(b);
    vec_len = 7'(vl); ew_code = 2'(w);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 200) begin
      if (disturb && n == 1) begin
        // R9 and R10: stray start and debug write while busy
        start = 1'b1; dst_base = 7'd0; src_a_base = 7'd1; src_b_base = 7'd2;
        vec_len = 7'd64; ew_code = 2'd3;
        dbg_we = 1'b1; dbg_addr = 7'd5; dbg_wdata = 64'hDEAD_BEEF_0BAD_F00D;
      end else begin
        start = 1'b0; dbg_we = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0; dbg_we = 1'b0;
    if (vl == 0) check(n == 0 && !busy, "R8", "zero-length completion delay", 64'(n), 64'd0);
    else         check(n == vl, "R7", $sformatf("cycles to done vl=%0d w=%0d", vl, w), 64'(n), 64'(vl));
    check(!busy, "R7", "busy low with done", 64'(busy), 64'd0);
    @(negedge clk);
    check(!done, "R7", "done lasts one cycle", 64'(done), 64'd0);
    model_op(d, a, b, vl, w, exp_err);
    check(err == exp_err, "R11", "error flag", 64'(err), 64'(exp_err));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!busy && !done && !err, "R1", "status after reset", {61'd0, busy, done, err}, 64'd0);
    verify_all("R1");

    // R2: debug write and read-back
    fill(1);
    verify_all("R2");

    // R3 R4 R5 R6 R7: sweep widths and lengths
    begin
      int vls [4] = '{1, 5, 17, 64};
      for (int w = 0; w < 4; w++) begin
        for (int vi = 0; vi < 4; vi++) begin
          fill(10 + w*4 + vi);
          run_op(50 + vi, vi*7 + w, 30 + w*3, vls[vi], w, 1'b0);
          verify_all("R3/R4/R5/R6");
        end
      end
    end

    // R4: carry is discarded at each width
    fill(40);
    dbg_write(10, 64'hFFFF_FFFF_FFFF_FFFF);
    dbg_write(11, 64'h0101_0101_0101_0101);
    run_op(12, 10, 11, 8, 0, 1'b0);
    @(negedge clk); dbg_addr = 7'd12; #1;
    check(dbg_rdata == 64'd0, "R4", "byte sums wrap to zero", dbg_rdata, 64'd0);
    dbg_write(11, 64'd1);
    run_op(13, 10, 11, 1, 3, 1'b0);
    @(negedge clk); dbg_addr = 7'd13; #1;
    check(dbg_rdata == 64'd0, "R4", "64-bit sum wraps", dbg_rdata, 64'd0);
    verify_all("R4");

    // R5: three halfwords leave the top two bytes intact
    fill(41);
    run_op(20, 21, 22, 3, 1, 1'b0);
    @(negedge clk); dbg_addr = 7'd20; #1;
    check(dbg_rdata[63:48] == pat(20, 41)[63:48], "R5", "untouched upper bytes",
          {48'd0, dbg_rdata[63:48]}, {48'd0, pat(20, 41)[63:48]});
    verify_all("R5");

    // R8: zero length leaves every register alone
    fill(42);
    run_op(0, 1, 2, 0, 2, 1'b0);
    verify_all("R8");

    // R9 R10: interference while busy
    fill(43);
    run_op(60, 70, 80, 9, 2, 1'b1);
    verify_all("R9/R10");

    // R11: destination runs past the last register
    fill(44);
    run_op(126, 0, 1, 4, 3, 1'b0);
    verify_all("R11");
    // R11: source runs past the last register
    run_op(0, 125, 2, 5, 3, 1'b0);
    verify_all("R11");
    // R11: flag cleared by the next accepted start
    run_op(40, 41, 42, 4, 0, 1'b0);
    check(err == 1'b0, "R11", "flag cleared by new op", 64'(err), 64'd0);
    verify_all("R11");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog (R7): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule